// File: doc/BRIEF.md
# Chip-Parallel Rake Finger Despreader

This block despreads one rake finger of one physical channel. On each accepted beat it takes a group of P consecutive complex data chips and one code chip per data chip from the scrambling sequence and one from the channelization sequence. It multiplies every data chip by the conjugate of the composite code, which is the product of the two code chips. Every code chip is a quarter-turn value (±1 or ±j), so this step needs no multipliers: it only swaps and negates the I and Q parts.

The P despread products feed a power-of-two reduction tree. The spreading factor S is a runtime input, given as log2(S). When S is no larger than P, one beat holds P/S whole symbols, and each symbol comes from the tree level whose partial sums span S chips. When S is larger than P, the whole-beat sum is a partial symbol, and an accumulator adds S/P such sums. A start flag on a beat begins a new symbol. Each finished symbol is multiplied by the conjugate of the path weight. The output carries a valid pulse and the number of symbols present.

Code generation, the chip delay line, channel estimation and combining across fingers are handled by neighbouring blocks.

Top module: `rake_finger_despreader`

## Requirements
- R1: Each code chip is 2 bits: 0 = +1, 1 = +j, 2 = −1, 3 = −j. For lane i the composite code c is the scrambling chip times the channelization chip. The despread product of lane i is x_i·conj(c), where data lane i sits at bits [i·DW +: DW] of the chip buses and its code chips sit at bits [2i +: 2].
- R2: For 2 ≤ log2(S) ≤ log2(P), an accepted beat yields sym_count = P/S symbols. Symbol n is the sum of the products of lanes n·S to n·S+S−1, and it appears in output lane n (bits [n·OW +: OW]).
- R3: For log2(S) > log2(P), the products of S/P accepted beats are summed into one symbol. The symbol is emitted only after the last of those beats, with sym_count = 1, in output lane 0.
- R4: An accepted beat with blk_start high is the first beat of a new symbol, and any partial sum collected before it is discarded.
- R5: Every emitted symbol equals conj(w)·sum, where w = w_re + j·w_im is sampled together with the beat that completes the symbol.
- R6: sym_valid is high exactly two clock cycles after an accepted beat that completes symbols, and it is high at no other time.
- R7: Output lanes at or above sym_count, and all lanes while sym_valid is low, read zero.
- R8: A sf_log2 value below 2 is treated as 2, and a value above 9 is treated as 9.
- R9: While rst is high, sym_valid, sym_count and all symbol lanes are zero.
- R10: A full-scale input of 512 chips, each −128 − j128 with code +1 and weight 1, yields exactly −65536 − j65536 with no wrap.
- R11: A cycle with in_valid low changes no state, even when blk_start is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the chip group in this cycle |
| blk_start | input | 1 | Accepted beat starts a new symbol |
| sf_log2 | input | 4 | log2 of the spreading factor |
| chip_re | input | P·DW | Real parts of P data chips |
| chip_im | input | P·DW | Imaginary parts of P data chips |
| scr_code | input | 2·P | Scrambling chips, 2 bits per lane |
| chn_code | input | 2·P | Channelization chips, 2 bits per lane |
| w_re | input | WW | Path weight, real part |
| w_im | input | WW | Path weight, imaginary part |
| sym_valid | output | 1 | Symbols are present |
| sym_count | output | log2(P/4)+1 | Number of valid symbol lanes |
| sym_re | output | (P/4)·OW | Real parts of the symbols |
| sym_im | output | (P/4)·OW | Imaginary parts of the symbols |

## Verification
Every short spreading factor (4, 8 and 16 with P = 16) is run with data and code patterns in which all four code values appear, so a wrong segment boundary or a wrong rotation direction changes a specific output lane. Long factors are driven with idle cycles between beats, and blk_start is raised during those idle cycles. This separates accumulation on accepted beats from unwanted reaction to idle cycles. A restart in the middle of a symbol, a full-scale all-negative block at the largest factor, and out-of-range factor codes test the discard, guard-bit and clamping behaviour. Non-trivial complex weights expose a missing conjugation or a swapped cross term.

// File: rtl/despread_pkg.sv
package despread_pkg;

    localparam int SF_LOG2_MIN = 2;
    localparam int SF_LOG2_MAX = 9;
    localparam int GUARD_BITS  = SF_LOG2_MAX;
    localparam int SFW         = 4;

    typedef enum logic [1:0] {
        QUAD_POS_ONE = 2'd0,
        QUAD_POS_J   = 2'd1,
        QUAD_NEG_ONE = 2'd2,
        QUAD_NEG_J   = 2'd3
    } quad_code_e;

    // Rotation that multiplies by the conjugate of the composite code.
    function automatic quad_code_e conj_composite(input logic [1:0] scr, input logic [1:0] chn);
        logic [1:0] sum;
        sum = scr + chn;
        return quad_code_e'(2'(2'd0 - sum));
    endfunction

    function automatic logic [SFW-1:0] clamp_sf(input logic [SFW-1:0] raw);
        if (raw < SFW'(SF_LOG2_MIN))      return SFW'(SF_LOG2_MIN);
        else if (raw > SFW'(SF_LOG2_MAX)) return SFW'(SF_LOG2_MAX);
        else                              return raw;
    endfunction

endpackage

// File: rtl/despread_lane.sv
module despread_lane
    import despread_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic [1:0]           scr_chip,
    input  logic [1:0]           chn_chip,
    output logic signed [DW:0]   p_re,
    output logic signed [DW:0]   p_im
);
    quad_code_e         rot;
    logic signed [DW:0] xr_w;
    logic signed [DW:0] xi_w;

    assign rot  = conj_composite(scr_chip, chn_chip);
    assign xr_w = {x_re[DW-1], x_re};
    assign xi_w = {x_im[DW-1], x_im};

    always_comb begin
        case (rot)
            QUAD_POS_J: begin
                p_re = -xi_w;
                p_im = xr_w;
            end
            QUAD_NEG_ONE: begin
                p_re = -xr_w;
                p_im = -xi_w;
            end
            QUAD_NEG_J: begin
                p_re = xi_w;
                p_im = -xr_w;
            end
            default: begin
                p_re = xr_w;
                p_im = xi_w;
            end
        endcase
    end
endmodule

// File: rtl/seg_adder_tree.sv
module seg_adder_tree #(
    parameter int P  = 16,
    parameter int PW = 9,
    parameter int AW = 18
) (
    input  logic [P-1:0][PW-1:0]               p_re,
    input  logic [P-1:0][PW-1:0]               p_im,
    output logic [$clog2(P):0][P-1:0][AW-1:0]  lv_re,
    output logic [$clog2(P):0][P-1:0][AW-1:0]  lv_im
);
    localparam int L = $clog2(P);

    // Level k holds P>>k sums, each spanning 2**k adjacent lanes.
    always_comb begin
        lv_re = '0;
        lv_im = '0;
        for (int j = 0; j < P; j++) begin
            lv_re[0][j] = {{(AW-PW){p_re[j][PW-1]}}, p_re[j]};
            lv_im[0][j] = {{(AW-PW){p_im[j][PW-1]}}, p_im[j]};
        end
        for (int k = 1; k <= L; k++) begin
            for (int j = 0; j < (P >> k); j++) begin
                lv_re[k][j] = lv_re[k-1][2*j] + lv_re[k-1][2*j+1];
                lv_im[k][j] = lv_im[k-1][2*j] + lv_im[k-1][2*j+1];
            end
        end
    end
endmodule

// File: rtl/symbol_integrator.sv
module symbol_integrator
    import despread_pkg::*;
#(
    parameter int P  = 16,
    parameter int AW = 18,
    parameter int WW = 8,
    parameter int NS = 4,
    parameter int CW = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic                               blk_start,
    input  logic [SFW-1:0]                     sf_eff,
    input  logic [$clog2(P):0][P-1:0][AW-1:0]  lv_re,
    input  logic [$clog2(P):0][P-1:0][AW-1:0]  lv_im,
    input  logic [WW-1:0]                      w_re,
    input  logic [WW-1:0]                      w_im,
    output logic                               s1_valid,
    output logic [CW-1:0]                      s1_count,
    output logic [NS-1:0][AW-1:0]              s1_re,
    output logic [NS-1:0][AW-1:0]              s1_im,
    output logic [WW-1:0]                      s1_wre,
    output logic [WW-1:0]                      s1_wim
);
    localparam int L    = $clog2(P);
    localparam int CNTW = SF_LOG2_MAX + 1;

    logic [AW-1:0]          acc_re, acc_im;
    logic [CNTW-1:0]        chunk_cnt;
    logic                   short_mode, first_beat, emit;
    logic [CNTW-1:0]        base_cnt, last_idx;
    logic [AW-1:0]          run_re, run_im;
    logic [CW-1:0]          cnt_now;
    logic [NS-1:0][AW-1:0]  seg_re, seg_im;
    int                     lvl;

    assign short_mode = (sf_eff <= SFW'(L));
    assign first_beat = blk_start || (chunk_cnt == '0);
    assign base_cnt   = first_beat ? '0 : chunk_cnt;
    assign last_idx   = (CNTW'(1) << (sf_eff - SFW'(L))) - CNTW'(1);
    assign run_re     = first_beat ? lv_re[L][0] : acc_re + lv_re[L][0];
    assign run_im     = first_beat ? lv_im[L][0] : acc_im + lv_im[L][0];

    always_comb begin
        seg_re  = '0;
        seg_im  = '0;
        cnt_now = '0;
        emit    = 1'b0;
        lvl     = int'(sf_eff);
        if (short_mode) begin
            emit    = in_valid;
            cnt_now = CW'(P >> lvl);
            for (int n = 0; n < NS; n++) begin
                if (n < (P >> lvl)) begin
                    seg_re[n] = lv_re[lvl][n];
                    seg_im[n] = lv_im[lvl][n];
                end
            end
        end else begin
            emit      = in_valid && (base_cnt == last_idx);
            cnt_now   = CW'(1);
            seg_re[0] = run_re;
            seg_im[0] = run_im;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_re    <= '0;
            acc_im    <= '0;
            chunk_cnt <= '0;
            s1_valid  <= 1'b0;
            s1_count  <= '0;
            s1_re     <= '0;
            s1_im     <= '0;
            s1_wre    <= '0;
            s1_wim    <= '0;
        end else begin
            s1_valid <= emit;
            s1_count <= emit ? cnt_now : '0;
            s1_re    <= emit ? seg_re : '0;
            s1_im    <= emit ? seg_im : '0;
            s1_wre   <= w_re;
            s1_wim   <= w_im;
            if (in_valid) begin
                if (short_mode || emit) begin
                    acc_re    <= '0;
                    acc_im    <= '0;
                    chunk_cnt <= '0;
                end else begin
                    acc_re    <= run_re;
                    acc_im    <= run_im;
                    chunk_cnt <= base_cnt + CNTW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/conj_weight_mult.sv
module conj_weight_mult #(
    parameter int NS = 4,
    parameter int AW = 18,
    parameter int WW = 8,
    parameter int CW = 3,
    parameter int OW = AW + WW + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   s1_valid,
    input  logic [CW-1:0]          s1_count,
    input  logic [NS-1:0][AW-1:0]  s1_re,
    input  logic [NS-1:0][AW-1:0]  s1_im,
    input  logic [WW-1:0]          w_re,
    input  logic [WW-1:0]          w_im,
    output logic                   o_valid,
    output logic [CW-1:0]          o_count,
    output logic [NS-1:0][OW-1:0]  o_re,
    output logic [NS-1:0][OW-1:0]  o_im
);
    logic [NS-1:0][OW-1:0] y_re, y_im;
    logic signed [OW-1:0]  wr_x, wi_x;

    assign wr_x = OW'($signed(w_re));
    assign wi_x = OW'($signed(w_im));

    for (genvar n = 0; n < NS; n++) begin : g_lane
        logic signed [OW-1:0] ar, ai;
        assign ar      = OW'($signed(s1_re[n]));
        assign ai      = OW'($signed(s1_im[n]));
        // (ar + j ai)(wr - j wi)
        assign y_re[n] = ar * wr_x + ai * wi_x;
        assign y_im[n] = ai * wr_x - ar * wi_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_count <= '0;
            o_re    <= '0;
            o_im    <= '0;
        end else begin
            o_valid <= s1_valid;
            o_count <= s1_valid ? s1_count : '0;
            o_re    <= s1_valid ? y_re : '0;
            o_im    <= s1_valid ? y_im : '0;
        end
    end
endmodule

// File: rtl/rake_finger_despreader.sv
module rake_finger_despreader
    import despread_pkg::*;
#(
    parameter int P  = 16,
    parameter int DW = 8,
    parameter int WW = 8
) (
    input  logic                                                  clk,
    input  logic                                                  rst,
    input  logic                                                  in_valid,
    input  logic                                                  blk_start,
    input  logic [SFW-1:0]                                        sf_log2,
    input  logic [P*DW-1:0]                                       chip_re,
    input  logic [P*DW-1:0]                                       chip_im,
    input  logic [2*P-1:0]                                        scr_code,
    input  logic [2*P-1:0]                                        chn_code,
    input  logic [WW-1:0]                                         w_re,
    input  logic [WW-1:0]                                         w_im,
    output logic                                                  sym_valid,
    output logic [$clog2(P >> SF_LOG2_MIN):0]                     sym_count,
    output logic [(P >> SF_LOG2_MIN)*(DW+WW+GUARD_BITS+2)-1:0]    sym_re,
    output logic [(P >> SF_LOG2_MIN)*(DW+WW+GUARD_BITS+2)-1:0]    sym_im
);
    localparam int L  = $clog2(P);
    localparam int PW = DW + 1;
    localparam int AW = PW + GUARD_BITS;
    localparam int NS = P >> SF_LOG2_MIN;
    localparam int CW = $clog2(NS) + 1;
    localparam int OW = AW + WW + 1;

    logic [SFW-1:0]               sf_eff;
    logic [P-1:0][PW-1:0]         prod_re, prod_im;
    logic [L:0][P-1:0][AW-1:0]    lv_re, lv_im;
    logic                         s1_valid;
    logic [CW-1:0]                s1_count;
    logic [NS-1:0][AW-1:0]        s1_re, s1_im;
    logic [WW-1:0]                s1_wre, s1_wim;
    logic [NS-1:0][OW-1:0]        o_re, o_im;

    assign sf_eff = clamp_sf(sf_log2);

    for (genvar i = 0; i < P; i++) begin : g_chip
        despread_lane #(.DW(DW)) u_lane (
            .x_re     (chip_re[i*DW +: DW]),
            .x_im     (chip_im[i*DW +: DW]),
            .scr_chip (scr_code[2*i +: 2]),
            .chn_chip (chn_code[2*i +: 2]),
            .p_re     (prod_re[i]),
            .p_im     (prod_im[i])
        );
    end

    seg_adder_tree #(.P(P), .PW(PW), .AW(AW)) u_tree (
        .p_re  (prod_re),
        .p_im  (prod_im),
        .lv_re (lv_re),
        .lv_im (lv_im)
    );

    symbol_integrator #(.P(P), .AW(AW), .WW(WW), .NS(NS), .CW(CW)) u_integ (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .blk_start (blk_start),
        .sf_eff    (sf_eff),
        .lv_re     (lv_re),
        .lv_im     (lv_im),
        .w_re      (w_re),
        .w_im      (w_im),
        .s1_valid  (s1_valid),
        .s1_count  (s1_count),
        .s1_re     (s1_re),
        .s1_im     (s1_im),
        .s1_wre    (s1_wre),
        .s1_wim    (s1_wim)
    );

    conj_weight_mult #(.NS(NS), .AW(AW), .WW(WW), .CW(CW), .OW(OW)) u_weight (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .s1_count (s1_count),
        .s1_re    (s1_re),
        .s1_im    (s1_im),
        .w_re     (s1_wre),
        .w_im     (s1_wim),
        .o_valid  (sym_valid),
        .o_count  (sym_count),
        .o_re     (o_re),
        .o_im     (o_im)
    );

    assign sym_re = o_re;
    assign sym_im = o_im;
endmodule

// File: rtl/despreader_checker.sv
module despreader_checker
    import despread_pkg::*;
#(
    parameter int P  = 16,
    parameter int DW = 8,
    parameter int WW = 8
) (
    input logic                                                clk,
    input logic                                                rst,
    input logic                                                in_valid,
    input logic                                                blk_start,
    input logic [SFW-1:0]                                      sf_log2,
    input logic                                                sym_valid,
    input logic [$clog2(P >> SF_LOG2_MIN):0]                   sym_count,
    input logic [(P >> SF_LOG2_MIN)*(DW+WW+GUARD_BITS+2)-1:0]  sym_re,
    input logic [(P >> SF_LOG2_MIN)*(DW+WW+GUARD_BITS+2)-1:0]  sym_im
);
    localparam int L  = $clog2(P);
    localparam int NS = P >> SF_LOG2_MIN;
    localparam int CW = $clog2(NS) + 1;
    localparam int OW = DW + WW + GUARD_BITS + 2;

    logic [1:0]     since_rst;
    logic           settled;
    logic           short_sf;
    logic [CW-1:0]  short_cnt;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    assign settled   = (since_rst == 2'd2);
    assign short_sf  = (clamp_sf(sf_log2) <= SFW'(L));
    assign short_cnt = CW'(P >> int'(clamp_sf(sf_log2)));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!sym_valid && sym_count == '0 && sym_re == '0 && sym_im == '0));

    assert_short_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (settled && $past(in_valid, 2) && $past(short_sf, 2)) |-> sym_valid);

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        (settled && !$past(in_valid, 2)) |-> !sym_valid);

    assert_short_count_R2: assert property (@(posedge clk) disable iff (rst)
        (settled && $past(in_valid, 2) && $past(short_sf, 2)) |-> (sym_count == $past(short_cnt, 2)));

    assert_long_single_R3: assert property (@(posedge clk) disable iff (rst)
        (settled && sym_valid && $past(in_valid, 2) && !$past(short_sf, 2)) |-> (sym_count == CW'(1)));

    assert_restart_no_emit_R4: assert property (@(posedge clk) disable iff (rst)
        (settled && $past(in_valid, 2) && $past(blk_start, 2) && !$past(short_sf, 2)) |-> !sym_valid);

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |-> (sym_re == '0 && sym_im == '0 && sym_count == '0));

    for (genvar n = 0; n < NS; n++) begin : g_lane_chk
        assert_unused_lane_zero_R7: assert property (@(posedge clk) disable iff (rst)
            (sym_valid && (CW'(n) >= sym_count)) |->
                (sym_re[n*OW +: OW] == '0 && sym_im[n*OW +: OW] == '0));
    end
endmodule

bind rake_finger_despreader despreader_checker #(.P(P), .DW(DW), .WW(WW)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .blk_start (blk_start),
    .sf_log2   (sf_log2),
    .sym_valid (sym_valid),
    .sym_count (sym_count),
    .sym_re    (sym_re),
    .sym_im    (sym_im)
);

// File: tb/rake_finger_despreader_test.sv
module rake_finger_despreader_test;
    localparam int P  = 16;
    localparam int DW = 8;
    localparam int WW = 8;
    localparam int NS = 4;
    localparam int OW = 27;
    localparam int CW = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid, blk_start;
    logic [3:0]        sf_log2;
    logic [P*DW-1:0]   chip_re, chip_im;
    logic [2*P-1:0]    scr_code, chn_code;
    logic [WW-1:0]     w_re, w_im;
    logic              sym_valid;
    logic [CW-1:0]     sym_count;
    logic [NS*OW-1:0]  sym_re, sym_im;

    always #5 clk = ~clk;

    rake_finger_despreader #(.P(P), .DW(DW), .WW(WW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .blk_start(blk_start),
        .sf_log2(sf_log2), .chip_re(chip_re), .chip_im(chip_im),
        .scr_code(scr_code), .chn_code(chn_code), .w_re(w_re), .w_im(w_im),
        .sym_valid(sym_valid), .sym_count(sym_count), .sym_re(sym_re), .sym_im(sym_im)
    );

    int checks = 0;
    int failures = 0;
    int xr[P], xq[P], sc[P], ch[P];
    int wr_v, wi_v;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint lane_re(input int n);
        return longint'($signed(sym_re[n*OW +: OW]));
    endfunction

    function automatic longint lane_im(input int n);
        return longint'($signed(sym_im[n*OW +: OW]));
    endfunction

    task automatic load(input int seed, input bit full_scale);
        for (int i = 0; i < P; i++) begin
            if (full_scale) begin
                xr[i] = -128; xq[i] = -128; sc[i] = 0; ch[i] = 0;
            end else begin
                xr[i] = ((i*29 + seed*53 + 7) % 256) - 128;
                xq[i] = ((i*71 + seed*17 + 91) % 256) - 128;
                sc[i] = (i*3 + seed) % 4;
                ch[i] = (i/2 + seed*3) % 4;
            end
        end
    endtask

    // x * conj(j^e), e = scrambling + channelization exponent (R1 encoding)
    task automatic chip_prod(input int i, output int pr, output int pi);
        int e, cr, ci;
        e = (sc[i] + ch[i]) % 4;
        case (e)
            0: begin cr = 1;  ci = 0;  end
            1: begin cr = 0;  ci = 1;  end
            2: begin cr = -1; ci = 0;  end
            default: begin cr = 0; ci = -1; end
        endcase
        pr = xr[i]*cr + xq[i]*ci;
        pi = xq[i]*cr - xr[i]*ci;
    endtask

    task automatic drive(input logic [3:0] sf, input bit blk);
        in_valid  = 1'b1;
        blk_start = blk;
        sf_log2   = sf;
        w_re      = WW'(wr_v);
        w_im      = WW'(wi_v);
        for (int i = 0; i < P; i++) begin
            chip_re[i*DW +: DW] = DW'(xr[i]);
            chip_im[i*DW +: DW] = DW'(xq[i]);
            scr_code[2*i +: 2]  = 2'(sc[i]);
            chn_code[2*i +: 2]  = 2'(ch[i]);
        end
        @(negedge clk);
        in_valid  = 1'b0;
        blk_start = 1'b1;   // must be ignored while in_valid is low (R11)
    endtask

    task automatic expect_sym(input string req, input int n, input longint sr, input longint si);
        check(req, $sformatf("lane%0d re", n), lane_re(n), sr*wr_v + si*wi_v);
        check(req, $sformatf("lane%0d im", n), lane_im(n), si*wr_v - sr*wi_v);
    endtask

    task automatic t_short(input logic [3:0] sf_in, input int s_len, input int seed,
                           input int w1, input int w2, input string req);
        int cnt, pr, pi;
        longint sr, si;
        load(seed, 1'b0);
        wr_v = w1; wi_v = w2;
        drive(sf_in, 1'b0);
        check("R6", "valid one cycle early", longint'(sym_valid), 0);
        @(negedge clk);
        check("R6", "valid at two cycles", longint'(sym_valid), 1);
        cnt = P / s_len;
        check(req, "sym_count", longint'(sym_count), longint'(cnt));
        for (int n = 0; n < NS; n++) begin
            if (n < cnt) begin
                sr = 0; si = 0;
                for (int c = n*s_len; c < (n+1)*s_len; c++) begin
                    chip_prod(c, pr, pi);
                    sr += pr; si += pi;
                end
                expect_sym(req, n, sr, si);
            end else begin
                check("R7", $sformatf("unused lane%0d re", n), lane_re(n), 0);
                check("R7", $sformatf("unused lane%0d im", n), lane_im(n), 0);
            end
        end
    endtask

    task automatic t_long(input logic [3:0] sf_in, input int s_len, input int restart,
                          input int seed, input bit full, input int w1, input int w2,
                          input string req);
        int beats, pr, pi;
        bit blk;
        longint sr, si;
        beats = s_len / P + restart;
        sr = 0; si = 0;
        wr_v = w1; wi_v = w2;
        for (int b = 0; b < beats; b++) begin
            load(seed + b, full);
            blk = (b == 0) || (restart > 0 && b == restart);
            if (blk) begin sr = 0; si = 0; end
            for (int c = 0; c < P; c++) begin
                chip_prod(c, pr, pi);
                sr += pr; si += pi;
            end
            drive(sf_in, blk);
            @(negedge clk);
            if (b < beats - 1) begin
                check("R11", $sformatf("no emit after beat %0d", b), longint'(sym_valid), 0);
                check("R7", "idle lane0 zero", lane_re(0), 0);
            end else begin
                check(req, "valid after last beat", longint'(sym_valid), 1);
                check(req, "sym_count", longint'(sym_count), 1);
                expect_sym(req, 0, sr, si);
                for (int n = 1; n < NS; n++)
                    check("R7", $sformatf("unused lane%0d", n), lane_re(n) | lane_im(n), 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; blk_start = 1'b0; sf_log2 = 4'd2;
        chip_re = '0; chip_im = '0; scr_code = '0; chn_code = '0;
        w_re = '0; w_im = '0; wr_v = 1; wi_v = 0;
        repeat (3) @(negedge clk);
        check("R9", "reset valid", longint'(sym_valid), 0);
        check("R9", "reset count", longint'(sym_count), 0);
        check("R9", "reset data", longint'(|{sym_re, sym_im}), 0);
        rst = 1'b0;
        @(negedge clk);

        t_short(4'd2, 4, 1, 1, 0, "R1");
        t_short(4'd3, 8, 2, 1, 0, "R2");
        t_short(4'd4, 16, 3, 3, -2, "R5");
        t_short(4'd0, 4, 4, -1, 2, "R8");
        t_long(4'd6, 64, 0, 5, 1'b0, 2, 1, "R3");
        t_long(4'd6, 64, 2, 9, 1'b0, 1, -1, "R4");
        t_long(4'd9, 512, 0, 0, 1'b1, 1, 0, "R10");
        t_long(4'd13, 512, 0, 20, 1'b0, 1, 1, "R8");
        t_long(4'd5, 32, 0, 30, 1'b0, -2, 3, "R11");

        blk_start = 1'b0;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule